// File: doc/BRIEF.md
# Interrupt routing and status decode

This block sits behind a set of latched interrupt-condition status bits. It steers every condition bit to one of several interrupt destinations and gives each destination a 32-bit read-only summary word. Five groups of conditions feed it: load/store completion flags for one core, a group of error, reset and special-event flags, one flag per transmit descriptor queue (16 of them), one flag per receive descriptor queue (16), and sixteen doorbell flags. Each flag has its own small routing register that holds a destination index. A flag only shows up in the summary word of the destination its routing register selects.

The placement of flags in the summary word is fixed in hardware. The whole load/store group collapses into the top bit, and the whole event group collapses into the next bit down. Queues occupy the upper half in reverse order, shared by the transmit and receive groups. Doorbells occupy the lower half in straight order. Each destination also drives one interrupt line that is high whenever its summary word is non-zero. Software reads the summary word to narrow down which small set of sources needs attention.

Routing registers are written through a plain write-enable, address and data port. Summary words and interrupt lines are registered, so each one follows its inputs with one clock of delay.

Top module: `irq_route_decode`

## Requirements
- R1: After reset every summary word and every interrupt line is 0, and every routing register holds destination 0.
- R2: Summary bit 31 of destination d is 1 when any load/store flag routed to d is set (it is also shared with queue 0, see R4).
- R3: Summary bit 30 of destination d is 1 when any error/reset/special-event flag routed to d is set (it is also shared with queue 1).
- R4: Transmit queue k and receive queue k (k = 0..15) both drive summary bit 31−k. For example, queue 2 of either group appears on bit 29.
- R5: Doorbell flag i (i = 0..15) drives summary bit i.
- R6: A flag contributes only to the destination whose index its routing register holds. It is never seen in any other destination's word.
- R7: When several routed flags share one summary bit, that bit is their logical OR.
- R8: A write with cfg_we = 1 and cfg_addr < NSRC stores cfg_wdata in the routing register of source cfg_addr. Sources are numbered from 0 in this order: load/store flags (LSU_W of them), event flags (EVT_W), transmit queues 0..15, receive queues 0..15, doorbells 0..15. A write to any higher address has no effect. This includes the addresses NSRC..NSRC+NUM_DEST−1, which name the read-only summary words.
- R9: Each summary word, and each interrupt line (the OR of that word), is registered. It reflects the flags and the routing registers as they stood before the previous rising edge. A routing write therefore shows up in the summary one cycle after it lands.
- R10: Clearing a flag at its source clears the bit it alone drove on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsu_pend | input | LSU_W | Load/store completion flags |
| evt_pend | input | EVT_W | Error, reset and special-event flags |
| txq_pend | input | 16 | Transmit descriptor-queue flags |
| rxq_pend | input | 16 | Receive descriptor-queue flags |
| dbell_pend | input | 16 | Doorbell flags |
| cfg_we | input | 1 | Routing-register write strobe |
| cfg_addr | input | AW | Write address (source index) |
| cfg_wdata | input | DW | Destination index to store |
| dec_word | output | NUM_DEST*32 | Summary words; destination d in bits 32d+31..32d |
| irq_out | output | NUM_DEST | Per-destination interrupt line |

## Verification
The bench aims at the shared bits. A design that dropped the queue reversal would put queue 2 on bit 2 instead of bit 29. A design that dropped the OR merge would lose a load/store flag when queue 0 was routed elsewhere. Routing is moved between destinations while flags stay set, which exposes a design that leaks a flag into every destination, or that shows a new route in the same cycle as the write instead of one cycle later. Writes aimed at the summary-word addresses and above must leave all routes untouched; a decoder that aliased them onto low sources would visibly re-route a doorbell.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int QUEUES  = 16;
    localparam int DBELLS  = 16;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
endpackage

// File: rtl/irq_route_table.sv
module irq_route_table #(
    parameter int NSRC = 64,
    parameter int DW   = 2,
    parameter int AW   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [NSRC*DW-1:0]   route_o
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [AW-1:0] SRC_LIM = AW'(NSRC);

    typedef struct packed {
        logic [NSRC-1:0][DW-1:0] route;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (addr < SRC_LIM)) begin
            st_d.route[addr[IW-1:0]] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_o = st_q.route;

    // R8: an in-range write lands in the addressed routing register
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr < SRC_LIM)) |=> (st_q.route[$past(addr[IW-1:0])] == $past(wdata)));

    // R8: writes at or above NSRC change no routing register
    p_ignored_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(addr < SRC_LIM)) |=> $stable(st_q.route));

    // R8: without a write strobe the table holds
    p_no_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.route));
endmodule

// File: rtl/irq_dest_fold.sv
module irq_dest_fold
    import irq_route_pkg::*;
#(
    parameter int LSU_W = 8,
    parameter int EVT_W = 8,
    parameter int NSRC  = 64,
    parameter int DW    = 2,
    parameter int DEST  = 0
) (
    input  logic [NSRC-1:0]      pend,
    input  logic [NSRC*DW-1:0]   route,
    output logic [WORD_W-1:0]    word
);
    localparam int EVT0 = LSU_W;
    localparam int TX0  = LSU_W + EVT_W;
    localparam int RX0  = TX0 + QUEUES;
    localparam int DB0  = RX0 + QUEUES;
    localparam logic [DW-1:0] MY_ID = DW'(DEST);

    logic [NSRC-1:0] hit;

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_hit
            assign hit[s] = pend[s] && (route[s*DW +: DW] == MY_ID);
        end
    endgenerate

    logic lsu_any;
    logic evt_any;

    always_comb begin
        lsu_any = 1'b0;
        for (int i = 0; i < LSU_W; i++) begin
            lsu_any = lsu_any | hit[i];
        end
        evt_any = 1'b0;
        for (int i = 0; i < EVT_W; i++) begin
            evt_any = evt_any | hit[EVT0 + i];
        end
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < QUEUES; k++) begin
            word[WORD_W-1-k] = hit[TX0 + k] | hit[RX0 + k];
        end
        word[WORD_W-1] = word[WORD_W-1] | lsu_any;
        word[WORD_W-2] = word[WORD_W-2] | evt_any;
        for (int i = 0; i < DBELLS; i++) begin
            word[i] = hit[DB0 + i];
        end
        // R6: nothing routed here and pending means an all-zero word
        if (hit == '0) begin
            p_quiet_when_unrouted_r6: assert (word == '0);
        end
    end
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int LSU_W    = 8,
    parameter int EVT_W    = 8,
    parameter int NUM_DEST = 4,
    localparam int NSRC    = LSU_W + EVT_W + 2*QUEUES + DBELLS,
    localparam int DW      = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    localparam int AW      = $clog2(NSRC + NUM_DEST + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LSU_W-1:0]             lsu_pend,
    input  logic [EVT_W-1:0]             evt_pend,
    input  logic [QUEUES-1:0]            txq_pend,
    input  logic [QUEUES-1:0]            rxq_pend,
    input  logic [DBELLS-1:0]            dbell_pend,
    input  logic                         cfg_we,
    input  logic [AW-1:0]                cfg_addr,
    input  logic [DW-1:0]                cfg_wdata,
    output logic [NUM_DEST*WORD_W-1:0]   dec_word,
    output logic [NUM_DEST-1:0]          irq_out
);
    typedef struct packed {
        logic [NUM_DEST-1:0][WORD_W-1:0] dec;
        logic [NUM_DEST-1:0]             irq;
    } out_t;

    out_t st_d, st_q;

    logic [NSRC-1:0]                 pend_all;
    logic [NSRC*DW-1:0]              route_flat;
    logic [NUM_DEST-1:0][WORD_W-1:0] fold_w;

    assign pend_all = {dbell_pend, rxq_pend, txq_pend, evt_pend, lsu_pend};

    irq_route_table #(
        .NSRC (NSRC),
        .DW   (DW),
        .AW   (AW)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .route_o (route_flat)
    );

    genvar d;
    generate
        for (d = 0; d < NUM_DEST; d++) begin : g_dest
            irq_dest_fold #(
                .LSU_W (LSU_W),
                .EVT_W (EVT_W),
                .NSRC  (NSRC),
                .DW    (DW),
                .DEST  (d)
            ) u_fold (
                .pend  (pend_all),
                .route (route_flat),
                .word  (fold_w[d])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_DEST; i++) begin
            st_d.dec[i] = fold_w[i];
            st_d.irq[i] = |fold_w[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_word = st_q.dec;
    assign irq_out  = st_q.irq;

    generate
        for (d = 0; d < NUM_DEST; d++) begin : g_chk_dest
            // R9: the interrupt line agrees with its own registered word
            p_irq_tracks_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[d] == (|dec_word[d*WORD_W +: WORD_W]));
            // R2: with no group or queue-0 flags, bit 31 drops next cycle
            p_top_bit_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
                ((lsu_pend == '0) && !txq_pend[0] && !rxq_pend[0])
                |=> !dec_word[d*WORD_W + WORD_W - 1]);
        end
    endgenerate

    genvar b;
    generate
        for (b = 0; b < DBELLS; b++) begin : g_chk_bell
            logic [NUM_DEST-1:0] bell_col;
            for (d = 0; d < NUM_DEST; d++) begin : g_col
                assign bell_col[d] = dec_word[d*WORD_W + b];
            end
            // R6: a doorbell appears in at most one destination
            p_bell_one_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(bell_col));
            // R10: a cleared doorbell is gone from every word next cycle
            p_bell_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !dbell_pend[b] |=> (bell_col == '0));
        end
    endgenerate
endmodule

// File: tb/sim_irq_route_decode.sv
module sim_irq_route_decode;
    localparam int LSU_W = 8;
    localparam int EVT_W = 8;
    localparam int ND    = 4;
    localparam int NSRC  = LSU_W + EVT_W + 48;
    localparam int DW    = 2;
    localparam int AW    = $clog2(NSRC + ND + 1);
    localparam int TX0   = LSU_W + EVT_W;
    localparam int RX0   = TX0 + 16;
    localparam int DB0   = RX0 + 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LSU_W-1:0] lsu_pend = '0;
    logic [EVT_W-1:0] evt_pend = '0;
    logic [15:0] txq_pend = '0;
    logic [15:0] rxq_pend = '0;
    logic [15:0] dbell_pend = '0;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [ND*32-1:0] dec_word;
    logic [ND-1:0] irq_out;

    always #2 clk = ~clk;

    irq_route_decode #(.LSU_W(LSU_W), .EVT_W(EVT_W), .NUM_DEST(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .lsu_pend(lsu_pend), .evt_pend(evt_pend),
        .txq_pend(txq_pend), .rxq_pend(rxq_pend), .dbell_pend(dbell_pend),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dec_word(dec_word), .irq_out(irq_out)
    );

    typedef struct {
        logic [ND*32-1:0] dec;
        logic [ND-1:0]    irq;
        string            tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] mroute [NSRC];
    logic [31:0] lfsr = 32'h1d2c3b4a;

    function automatic logic [ND*32-1:0] model();
        logic [ND*32-1:0] w = '0;
        for (int d = 0; d < ND; d++) begin
            for (int i = 0; i < LSU_W; i++)
                if (lsu_pend[i] && mroute[i] == d) w[d*32+31] = 1'b1;
            for (int i = 0; i < EVT_W; i++)
                if (evt_pend[i] && mroute[LSU_W+i] == d) w[d*32+30] = 1'b1;
            for (int k = 0; k < 16; k++) begin
                if (txq_pend[k] && mroute[TX0+k] == d) w[d*32+31-k] = 1'b1;
                if (rxq_pend[k] && mroute[RX0+k] == d) w[d*32+31-k] = 1'b1;
            end
            for (int i = 0; i < 16; i++)
                if (dbell_pend[i] && mroute[DB0+i] == d) w[d*32+i] = 1'b1;
        end
        return w;
    endfunction

    task automatic step(input logic [LSU_W-1:0] l, input logic [EVT_W-1:0] e,
                        input logic [15:0] t, input logic [15:0] r, input logic [15:0] b,
                        input logic we, input int addr, input int wd, input string tag);
        exp_t it;
        @(negedge clk);
        lsu_pend = l; evt_pend = e; txq_pend = t; rxq_pend = r; dbell_pend = b;
        cfg_we = we; cfg_addr = AW'(addr); cfg_wdata = DW'(wd);
        it.dec = model();
        for (int d = 0; d < ND; d++) it.irq[d] = |it.dec[d*32 +: 32];
        it.tag = tag;
        sb.push_back(it);
        if (we && addr < NSRC) mroute[addr] = DW'(wd);
    endtask

    task automatic route(input int src, input int dst, input string tag);
        step(lsu_pend, evt_pend, txq_pend, rxq_pend, dbell_pend, 1'b1, src, dst, tag);
        step(lsu_pend, evt_pend, txq_pend, rxq_pend, dbell_pend, 1'b0, 0, 0, tag);
    endtask

    task automatic hold(input string tag);
        step(lsu_pend, evt_pend, txq_pend, rxq_pend, dbell_pend, 1'b0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                n_chk++;
                if (dec_word !== it.dec) begin
                    n_bad++;
                    $display("FAIL %s decode actual %h expected %h", it.tag, dec_word, it.dec);
                end
                n_chk++;
                if (irq_out !== it.irq) begin
                    n_bad++;
                    $display("FAIL %s irq actual %b expected %b", it.tag, irq_out, it.irq);
                end
            end
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : driver
        for (int s = 0; s < NSRC; s++) mroute[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_chk++;
        if (dec_word !== '0 || irq_out !== '0) begin
            n_bad++;
            $display("FAIL R1 reset actual %h/%b expected 0/0", dec_word, irq_out);
        end
        // R1: default route is destination 0
        step('0, '0, '0, '0, 16'h0001, 1'b0, 0, 0, "R1");
        hold("R1");
        // R2: any load/store flag to bit 31
        step(8'h40, '0, '0, '0, '0, 1'b0, 0, 0, "R2");
        step(8'h81, '0, '0, '0, '0, 1'b0, 0, 0, "R2");
        // R3: event group to bit 30
        step('0, 8'h10, '0, '0, '0, 1'b0, 0, 0, "R3");
        step('0, 8'hff, '0, '0, '0, 1'b0, 0, 0, "R3");
        // R4: queue reversal, queue 2 on bit 29
        step('0, '0, 16'h0004, '0, '0, 1'b0, 0, 0, "R4");
        step('0, '0, '0, 16'h0020, '0, 1'b0, 0, 0, "R4");
        step('0, '0, 16'h8000, 16'h4000, '0, 1'b0, 0, 0, "R4");
        // R5: doorbells straight through
        for (int i = 0; i < 16; i++) step('0, '0, '0, '0, 16'(1 << i), 1'b0, 0, 0, "R5");
        // R10: clearing drops next cycle
        step('0, '0, '0, '0, '0, 1'b0, 0, 0, "R10");
        // R6/R9: move doorbell 3 to destination 2 while pending
        step('0, '0, '0, '0, 16'h0008, 1'b0, 0, 0, "R6");
        route(DB0 + 3, 2, "R9");
        route(TX0 + 0, 3, "R6");
        // R7: shared top bit, load/store on dest 0, queue 0 on dest 3
        step(8'h02, '0, 16'h0001, '0, 16'h0008, 1'b0, 0, 0, "R7");
        route(0, 3, "R7");
        step(8'h03, '0, 16'h0001, 16'h0001, 16'h0008, 1'b0, 0, 0, "R7");
        // R8: writes to summary addresses and above are ignored
        for (int a = NSRC; a < NSRC + ND; a++) route(a, 1, "R8");
        route((1 << AW) - 1, 1, "R8");
        step(8'hff, 8'hff, 16'hffff, 16'hffff, 16'hffff, 1'b0, 0, 0, "R8");
        hold("R8");
        // R10: clear everything at once
        step('0, '0, '0, '0, '0, 1'b0, 0, 0, "R10");
        hold("R10");
        // R6/R7: mixed random traffic and routing
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a, b2;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b2 = lfsr;
            step(a[7:0] & b2[7:0], a[15:8] & b2[15:8], a[31:16] & b2[15:0],
                 b2[31:16] & a[15:0], a[31:16] ^ b2[7:0],
                 b2[3], int'(a[6:0]), int'(b2[9:8]), "R6 R7 random");
        end
        hold("R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule